// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block is the digital decision stage of a single-phase buck controller's protection path. Analog comparators outside it report an enable level, a supply-lockout flag, soft-start and reference-transition status, and four fault conditions:
- output high against its target window
- output above an absolute ceiling
- output low against its target window
- over-temperature

It also receives a pulse for each current-limit event and a tick once per switching cycle. From these it produces a gate-driver command, a command that discharges the soft-start capacitor, and a code for the fault that has latched.

Supply lockout and disable are not latched. Both gate drivers stay off while either is present, and the soft-start capacitor is discharged. The other protections latch. The two over-voltage cases clamp the low-side switch on. Over-temperature and sustained current limiting turn both switches off.

The window over-voltage check is ignored during soft-start and during reference transitions. The absolute ceiling check is never ignored. Current-limit shutdown counts switching cycles that contain current-limit activity, but only while the output is below its window and soft-start has finished. A latched fault is cleared only by pulling enable low or by a lockout.

Top module: `prot_latch_ctrl`

## Requirements
- R1: During reset, `drv_o` is 1 (both switches off), `ss_dis_o` is 1 and `fault_o` is 0 (no fault).
- R2: One clock edge after `en_i` is low or `uvlo_i` is high, `drv_o` is 1 and `ss_dis_o` is 1. This state is not latched: once enabled and out of lockout with no fault, `drv_o` returns to 0 (normal switching) one edge later.
- R3: `ss_dis_o` is 0 whenever the block is enabled and out of lockout, including while a fault is latched.
- R4: `ov_abs_i` high while enabled latches `fault_o`=1 with `drv_o`=2 (high side off, low side forced on), whatever the soft-start and transition flags are.
- R5: `ov_win_i` latches `fault_o`=2 with `drv_o`=2, but only when `ss_done_i` is 1 and `trans_i` is 0. Otherwise it is ignored, and `drv_o` stays 0.
- R6: `ot_i` high while enabled latches `fault_o`=3 with `drv_o`=1, regardless of soft-start or transitions.
- R7: A switching cycle (ended by `cyc_tick_i`) that contains at least one `ilim_pulse_i` counts once, provided `uv_win_i` is 1 and `ss_done_i` is 1. The edge after the LIMIT-th (default 32) counted cycle latches `fault_o`=4 with `drv_o`=1.
- R8: The current-limit count returns to zero when `uv_win_i` falls, when `ss_done_i` is 0, or when the block is disabled. Several pulses in one switching cycle count as one, and a tick with no pulse adds nothing.
- R9: A latched fault holds after its cause is removed, and a later fault does not change the code. Only `en_i` low or `uvlo_i` high clears it.
- R10: When faults arrive together, the code chosen follows the order absolute over-voltage (1), window over-voltage (2), over-temperature (3), current limit (4).
- R11: Every output reflects its inputs after exactly one rising clock edge. The current-limit trip takes one further edge after the counting tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable, active high |
| uvlo_i | input | 1 | Supply lockout active |
| ss_done_i | input | 1 | Soft-start ramp finished |
| trans_i | input | 1 | Reference (VID/sleep) transition in progress |
| ov_win_i | input | 1 | Output above +14 % of target |
| ov_abs_i | input | 1 | Output above 2 V absolute |
| uv_win_i | input | 1 | Output below -14 % of target |
| ot_i | input | 1 | Over-temperature |
| ilim_pulse_i | input | 1 | One-cycle pulse per current-limit event |
| cyc_tick_i | input | 1 | One-cycle tick per switching cycle |
| drv_o | output | 2 | Driver command: 0 switch, 1 both off, 2 low side on |
| ss_dis_o | output | 1 | Discharge soft-start capacitor |
| fault_o | output | 3 | Latched fault code 0..4 |

## Verification
A wrong latch state appears on `fault_o` and `drv_o` one edge after the stimulus. This shows up as a masked window fault that latches, an unmasked one that does not, or a code that changes while the fault is already latched. A wrong count in the current-limit counter is only visible when it trips. The bench therefore probes the trip boundary exactly: it expects no fault after LIMIT-1 counted cycles and expects the fault one edge after the LIMIT-th. It repeats this after each way the count can be cleared, so an off-by-one or a missed clear shows up within one switching cycle of the limit.

// File: rtl/prot_pkg.sv
package prot_pkg;
    typedef enum logic [1:0] {
        DRV_RUN   = 2'd0,
        DRV_OFF   = 2'd1,
        DRV_CLAMP = 2'd2
    } drv_cmd_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_OV_ABS = 3'd1,
        FLT_OV_WIN = 3'd2,
        FLT_THERM  = 3'd3,
        FLT_ILIM   = 3'd4
    } flt_code_e;
endpackage

// File: rtl/prot_ilim_count.sv
module prot_ilim_count #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pulse_i,
    input  logic tick_i,
    output logic trip_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
        end else if (tick_i) begin
            if ((st_q.seen || pulse_i) && (st_q.cnt != CW'(LIMIT)))
                st_d.cnt = st_q.cnt + 1'b1;
            st_d.seen = 1'b0;
        end else if (pulse_i) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip_o = (st_q.cnt == CW'(LIMIT));

    // R7: the count moves up by exactly one step
    a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt) && st_q.cnt != '0) |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R7: a trip only follows a switching-cycle tick
    a_r7_trip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(tick_i));
    // R8: clearing empties the counter
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !trip_o);
endmodule

// File: rtl/prot_fault_latch.sv
module prot_fault_latch
    import prot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_i,
    input  logic      win_ok_i,
    input  logic      ov_abs_i,
    input  logic      ov_win_i,
    input  logic      ot_i,
    input  logic      trip_i,
    output flt_code_e code_o
);
    typedef struct packed {
        flt_code_e code;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!arm_i)
            st_d.code = FLT_NONE;
        else if (st_q.code == FLT_NONE) begin
            if (ov_abs_i)                  st_d.code = FLT_OV_ABS;
            else if (ov_win_i && win_ok_i) st_d.code = FLT_OV_WIN;
            else if (ot_i)                 st_d.code = FLT_THERM;
            else if (trip_i)               st_d.code = FLT_ILIM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code: FLT_NONE};
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;

    // R9: a latched code holds while armed
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != FLT_NONE && arm_i) |=> (st_q.code == $past(st_q.code)));
    // R5: masked window fault alone does not latch
    a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code == FLT_NONE && arm_i && !win_ok_i && !ov_abs_i && !ot_i && !trip_i)
        |=> (st_q.code == FLT_NONE));
    // R10: absolute over-voltage wins over everything
    a_r10_abs_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code == FLT_NONE && arm_i && ov_abs_i) |=> (st_q.code == FLT_OV_ABS));
endmodule

// File: rtl/prot_latch_ctrl.sv
module prot_latch_ctrl
    import prot_pkg::*;
#(
    parameter int ILIM_LIMIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       uvlo_i,
    input  logic       ss_done_i,
    input  logic       trans_i,
    input  logic       ov_win_i,
    input  logic       ov_abs_i,
    input  logic       uv_win_i,
    input  logic       ot_i,
    input  logic       ilim_pulse_i,
    input  logic       cyc_tick_i,
    output logic [1:0] drv_o,
    output logic       ss_dis_o,
    output logic [2:0] fault_o
);
    typedef struct packed {
        logic active;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       arm;
    logic       cnt_clr;
    logic       trip;
    flt_code_e  code;
    drv_cmd_e   drv;

    assign arm     = en_i && !uvlo_i;
    assign cnt_clr = !arm || !uv_win_i || !ss_done_i;

    prot_ilim_count #(.LIMIT(ILIM_LIMIT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .pulse_i (ilim_pulse_i),
        .tick_i  (cyc_tick_i),
        .trip_o  (trip)
    );

    prot_fault_latch u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .win_ok_i (ss_done_i && !trans_i),
        .ov_abs_i (ov_abs_i),
        .ov_win_i (ov_win_i),
        .ot_i     (ot_i),
        .trip_i   (trip),
        .code_o   (code)
    );

    always_comb begin
        st_d = st_q;
        st_d.active = arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!st_q.active) drv = DRV_OFF;
        else begin
            unique case (code)
                FLT_OV_ABS, FLT_OV_WIN: drv = DRV_CLAMP;
                FLT_THERM, FLT_ILIM:    drv = DRV_OFF;
                default:                drv = DRV_RUN;
            endcase
        end
    end

    assign drv_o    = drv;
    assign ss_dis_o = !st_q.active;
    assign fault_o  = code;

    // R2: disable or lockout turns both switches off and discharges soft-start
    a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_i || !en_i) |=> (drv_o == 2'd1 && ss_dis_o));
    // R3: no discharge while enabled
    a_r3_ss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !uvlo_i) |=> !ss_dis_o);
    // R4: absolute over-voltage clamps the low side
    a_r4_abs_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_abs_i && en_i && !uvlo_i && fault_o == 3'd0) |=> (drv_o == 2'd2));
    // R6: over-temperature turns both off
    a_r6_therm_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_i && !ov_abs_i && !ov_win_i && en_i && !uvlo_i && fault_o == 3'd0) |=> (drv_o == 2'd1));
endmodule

// File: tb/prot_latch_ctrl_tb.sv
module prot_latch_ctrl_tb;
    localparam int LIM = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 0, uvlo_i = 0, ss_done_i = 0, trans_i = 0;
    logic ov_win_i = 0, ov_abs_i = 0, uv_win_i = 0, ot_i = 0;
    logic ilim_pulse_i = 0, cyc_tick_i = 0;
    logic [1:0] drv_o;
    logic       ss_dis_o;
    logic [2:0] fault_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prot_latch_ctrl #(.ILIM_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
        .ss_done_i(ss_done_i), .trans_i(trans_i), .ov_win_i(ov_win_i),
        .ov_abs_i(ov_abs_i), .uv_win_i(uv_win_i), .ot_i(ot_i),
        .ilim_pulse_i(ilim_pulse_i), .cyc_tick_i(cyc_tick_i),
        .drv_o(drv_o), .ss_dis_o(ss_dis_o), .fault_o(fault_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, int e_drv, int e_ss, int e_flt);
        n_chk++;
        if (int'(drv_o) != e_drv || int'(ss_dis_o) != e_ss || int'(fault_o) != e_flt) begin
            n_bad++;
            $display("FAIL %s: drv/ss/fault actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, drv_o, ss_dis_o, fault_o, e_drv, e_ss, e_flt);
        end
    endtask

    task automatic rearm();
        en_i = 0; step();
        en_i = 1; step();
    endtask

    task automatic sw_cycle(int pulses);
        for (int p = 0; p < pulses; p++) begin
            ilim_pulse_i = 1; step(); ilim_pulse_i = 0;
        end
        cyc_tick_i = 1; step(); cyc_tick_i = 0;
    endtask

    function automatic int code_of(bit a, bit w, bit t, bit ss, bit tr);
        if (a) return 1;
        if (w && ss && !tr) return 2;
        if (t) return 3;
        return 0;
    endfunction

    function automatic int drv_of(int c);
        if (c == 1 || c == 2) return 2;
        if (c == 3 || c == 4) return 1;
        return 0;
    endfunction

    initial begin
        repeat (3) step();
        check("R1 reset", 1, 1, 0);
        rst_n = 1;
        step();
        check("R2 disabled after reset", 1, 1, 0);

        // R4 R5 R6 R10 sweep over fault and mask flags
        for (int k = 0; k < 32; k++) begin
            int ec;
            rearm();
            check("R2 unlatched run", 0, 0, 0);
            ov_abs_i = k[0]; ov_win_i = k[1]; ot_i = k[2];
            ss_done_i = k[3]; trans_i = k[4];
            step();
            ec = code_of(k[0], k[1], k[2], k[3], k[4]);
            check("R4/R5/R6/R10 sweep", drv_of(ec), 0, ec);
            ov_abs_i = 0; ov_win_i = 0; ot_i = 0; trans_i = 0;
        end

        // R9 hold and R3 no discharge while latched
        ss_done_i = 1;
        rearm();
        ov_win_i = 1; step(); ov_win_i = 0;
        step();
        check("R9 hold after cause gone", 2, 0, 2);
        ot_i = 1; step(); ot_i = 0;
        check("R9 later fault ignored R3", 2, 0, 2);
        en_i = 0; step();
        check("R9 cleared by enable low", 1, 1, 0);
        en_i = 1; step();
        check("R2 back to run", 0, 0, 0);

        // R2 lockout clears a latched fault
        ot_i = 1; step(); ot_i = 0;
        check("R6 thermal", 1, 0, 3);
        uvlo_i = 1; step();
        check("R2 lockout", 1, 1, 0);
        uvlo_i = 0; step();
        check("R2 lockout released", 0, 0, 0);

        // R7 exact trip boundary, R11 extra edge
        uv_win_i = 1;
        for (int i = 0; i < LIM - 1; i++) sw_cycle(1);
        check("R7 below limit", 0, 0, 0);
        sw_cycle(1);
        check("R11 trip not yet visible", 0, 0, 0);
        step();
        check("R7 trip", 1, 0, 4);

        // R8 multiple pulses per cycle and empty ticks
        rearm();
        for (int i = 0; i < LIM - 1; i++) begin
            sw_cycle(3);
            sw_cycle(0);
        end
        step();
        check("R8 multi pulse counts once", 0, 0, 0);
        sw_cycle(2); step();
        check("R8 trip at limit", 1, 0, 4);

        // R8 clear when leaving the lower window
        rearm();
        for (int i = 0; i < 20; i++) sw_cycle(1);
        uv_win_i = 0; step(); uv_win_i = 1;
        for (int i = 0; i < LIM - 1; i++) sw_cycle(1);
        step();
        check("R8 cleared by window exit", 0, 0, 0);
        sw_cycle(1); step();
        check("R8 trip after clear", 1, 0, 4);

        // R8 inhibit during soft-start
        rearm();
        ss_done_i = 0;
        for (int i = 0; i < LIM + 8; i++) sw_cycle(1);
        step();
        check("R8 soft-start inhibits count", 0, 0, 0);
        ss_done_i = 1;

        // R10 thermal wins over a simultaneous current-limit trip
        rearm();
        for (int i = 0; i < LIM; i++) sw_cycle(1);
        ot_i = 1; step(); ot_i = 0;
        check("R10 thermal before current limit", 1, 0, 3);

        // R4 during soft-start and transition
        rearm();
        ss_done_i = 0; trans_i = 1; ov_abs_i = 1; ov_win_i = 1;
        step();
        check("R4 unmasked", 2, 0, 1);
        ov_abs_i = 0; ov_win_i = 0; trans_i = 0; uv_win_i = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule